// File: doc/BRIEF.md
# Halt and Snoop Power-State Sequencer

This block sits beside one processor core and decides which power state the core is in. While the core runs, it sees a stream of operating-point settings: a bus-to-core ratio and a supply VID code. When the core asks to halt, the block moves to one of two halt states. In plain halt it keeps the operating point it had. In extended halt it switches to a reduced ratio and VID pair. That pair is captured from configuration inputs during synchronous reset.

Each halt state has a snoop sub-state. A snoop request moves the core into it and raises a service enable. The snoop logic outside this block reports completion on `snoop_done`. The block then drops back into the halt state it came from, and it never wakes the core on that path. In the extended case the reduced operating point stays in force the whole time.

An interrupt that arrives in a halt state wakes the core to the run state and restores the operating point it had when it halted. An interrupt that arrives during a snoop is latched and acted on once the snoop is finished. A snoop request that arrives during a snoop is also latched, so snoops are serviced one at a time.

The five states are RUN, HALT, HALT_SNOOP, XHALT (extended halt) and XHALT_SNOOP. The transitions are:
- enter_halt: RUN to HALT.
- enter_xhalt: RUN to XHALT.
- snoop_start: HALT to HALT_SNOOP, or XHALT to XHALT_SNOOP.
- snoop_end: each snoop sub-state back to its own halt state.
- wake: HALT or XHALT to RUN.

Top module: `halt_pwr_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to RUN with `snoop_en` low. At that edge `ratio_o`/`vid_o` take `run_ratio`/`run_vid`, and the extended-halt pair is loaded from `xh_ratio_cfg`/`xh_vid_cfg`.
- R2: `state_o` is one-hot with these bit positions: RUN bit 0, HALT bit 1, HALT_SNOOP bit 2, XHALT bit 3, XHALT_SNOOP bit 4.
- R3: In RUN, `ratio_o`/`vid_o` show the values `run_ratio`/`run_vid` had at the previous clock edge. `snoop_req`, `intr` and `snoop_done` do not change the state in RUN.
- R4: `halt_req` in RUN with `xhalt_en` low moves the block to HALT at the next edge, and the operating point stays unchanged.
- R5: `halt_req` in RUN with `xhalt_en` high moves the block to XHALT, and the outputs take the extended pair captured at reset. Changes to the configuration inputs after reset have no effect.
- R6: A snoop request in HALT moves the block to HALT_SNOOP, and in XHALT to XHALT_SNOOP. `snoop_en` is high in the snoop sub-states and only there.
- R7: Throughout XHALT_SNOOP, `ratio_o`/`vid_o` hold the extended pair.
- R8: `snoop_done` in a snoop sub-state returns the block to its own halt state (HALT_SNOOP to HALT, XHALT_SNOOP to XHALT), never to RUN.
- R9: `intr` in HALT or XHALT with no snoop pending moves the block to RUN at the next edge. The outputs then show the operating point held at halt entry, even if the run inputs changed during the halt.
- R10: An `intr` received during a snoop sub-state is latched. After `snoop_done`, the block spends one cycle in its halt state and then moves to RUN.
- R11: A `snoop_req` received during a snoop sub-state is latched. After `snoop_done`, the block spends one cycle in its halt state and then enters the snoop sub-state again.
- R12: If `snoop_req` and `intr` arrive in the same cycle in a halt state, the snoop is served first and the interrupt is latched.
- R13: In a halt state, `halt_req` has no effect. Outside the snoop sub-states, `snoop_done` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt_req | input | 1 | Pulse asking the core to halt |
| xhalt_en | input | 1 | Selects extended halt when a halt is entered |
| snoop_req | input | 1 | Pulse announcing a snoop |
| intr | input | 1 | Pulse for an unmasked interrupt |
| snoop_done | input | 1 | Pulse reporting the snoop has been serviced |
| run_ratio | input | RATIO_W | Ratio requested while running |
| run_vid | input | VID_W | VID requested while running |
| xh_ratio_cfg | input | RATIO_W | Extended-halt ratio, captured at reset |
| xh_vid_cfg | input | VID_W | Extended-halt VID, captured at reset |
| state_o | output | 5 | One-hot current state |
| ratio_o | output | RATIO_W | Active ratio |
| vid_o | output | VID_W | Active VID |
| snoop_en | output | 1 | Snoop service enable |

## Verification
Halts are entered once with extended halt disabled and once with it enabled. This shows whether the configuration bit alone picks between keeping the operating point and switching to the reduced pair. The run inputs are changed during a halt, so a block that restores the saved point can be told apart from one that simply follows its inputs. Interrupts and snoop requests are sent in three ways: alone, in the middle of a snoop, and in the same cycle. These cases separate a direct wake from a deferred wake, and a queued snoop from a dropped one. Pulses of `halt_req` and `snoop_done` in states where they must be ignored check that those states hold.

// File: rtl/hps_pkg.sv
package hps_pkg;

    localparam int ST_W = 5;

    typedef enum logic [ST_W-1:0] {
        ST_RUN        = 5'b00001,
        ST_HALT       = 5'b00010,
        ST_HALT_SNOOP = 5'b00100,
        ST_XHALT      = 5'b01000,
        ST_XHALT_SNP  = 5'b10000
    } hps_state_e;

endpackage

// File: rtl/hps_flag.sv
// Single pending-event latch; set wins over clear.
module hps_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/hps_fsm.sv
module hps_fsm
    import hps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_req,
    input  logic       xhalt_en,
    input  logic       snp_go,
    input  logic       wake,
    input  logic       snoop_done,
    output hps_state_e state_q,
    output hps_state_e state_d,
    output logic       in_halt,
    output logic       in_snoop
);
    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (halt_req) state_d = xhalt_en ? ST_XHALT : ST_HALT;
            end
            ST_HALT: begin
                if (snp_go)    state_d = ST_HALT_SNOOP;
                else if (wake) state_d = ST_RUN;
            end
            ST_HALT_SNOOP: begin
                if (snoop_done) state_d = ST_HALT;
            end
            ST_XHALT: begin
                if (snp_go)    state_d = ST_XHALT_SNP;
                else if (wake) state_d = ST_RUN;
            end
            ST_XHALT_SNP: begin
                if (snoop_done) state_d = ST_XHALT;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    // decoded outputs
    always_comb begin
        in_halt  = 1'b0;
        in_snoop = 1'b0;
        unique case (state_q)
            ST_HALT, ST_XHALT:           in_halt  = 1'b1;
            ST_HALT_SNOOP, ST_XHALT_SNP: in_snoop = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/hps_oppt.sv
// Operating-point selection: live run point, saved point, extended-halt pair.
module hps_oppt
    import hps_pkg::*;
#(
    parameter int RATIO_W = 6,
    parameter int VID_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  hps_state_e         state_q,
    input  hps_state_e         state_d,
    input  logic [RATIO_W-1:0] run_ratio,
    input  logic [VID_W-1:0]   run_vid,
    input  logic [RATIO_W-1:0] xh_ratio_cfg,
    input  logic [VID_W-1:0]   xh_vid_cfg,
    output logic [RATIO_W-1:0] ratio_q,
    output logic [VID_W-1:0]   vid_q
);
    localparam int OP_W = RATIO_W + VID_W;

    logic [OP_W-1:0] xh_pt;
    logic [OP_W-1:0] sav_pt;
    logic [OP_W-1:0] cur_pt;
    logic [OP_W-1:0] nxt_pt;

    assign {ratio_q, vid_q} = cur_pt;

    always_comb begin
        nxt_pt = cur_pt;
        unique case (state_d)
            ST_RUN: begin
                if (state_q == ST_RUN) nxt_pt = {run_ratio, run_vid};
                else                   nxt_pt = sav_pt;
            end
            ST_XHALT, ST_XHALT_SNP: nxt_pt = xh_pt;
            default: nxt_pt = cur_pt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xh_pt  <= {xh_ratio_cfg, xh_vid_cfg};
            cur_pt <= {run_ratio, run_vid};
            sav_pt <= {run_ratio, run_vid};
        end else begin
            cur_pt <= nxt_pt;
            if (state_q == ST_RUN && state_d != ST_RUN) sav_pt <= cur_pt;
        end
    end
endmodule

// File: rtl/halt_pwr_ctrl.sv
module halt_pwr_ctrl
    import hps_pkg::*;
#(
    parameter int RATIO_W = 6,
    parameter int VID_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               halt_req,
    input  logic               xhalt_en,
    input  logic               snoop_req,
    input  logic               intr,
    input  logic               snoop_done,
    input  logic [RATIO_W-1:0] run_ratio,
    input  logic [VID_W-1:0]   run_vid,
    input  logic [RATIO_W-1:0] xh_ratio_cfg,
    input  logic [VID_W-1:0]   xh_vid_cfg,
    output logic [ST_W-1:0]    state_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [VID_W-1:0]   vid_o,
    output logic               snoop_en
);
    hps_state_e state_q;
    hps_state_e state_d;
    logic       in_halt;
    logic       in_snoop;
    logic       snp_pend;
    logic       int_pend;
    logic       snp_go;
    logic       wake;

    assign snp_go = snoop_req | snp_pend;
    assign wake   = intr | int_pend;

    hps_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .halt_req   (halt_req),
        .xhalt_en   (xhalt_en),
        .snp_go     (snp_go),
        .wake       (wake),
        .snoop_done (snoop_done),
        .state_q    (state_q),
        .state_d    (state_d),
        .in_halt    (in_halt),
        .in_snoop   (in_snoop)
    );

    // snoop arriving mid-service waits; launch from halt consumes it
    hps_flag u_snp_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (snoop_req & in_snoop),
        .clr_i (in_halt & snp_go),
        .q_o   (snp_pend)
    );

    // interrupt deferred by a snoop waits until the wake transition
    hps_flag u_int_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (intr & (in_snoop | (in_halt & snp_go))),
        .clr_i (in_halt & (state_d == ST_RUN)),
        .q_o   (int_pend)
    );

    hps_oppt #(
        .RATIO_W (RATIO_W),
        .VID_W   (VID_W)
    ) u_oppt (
        .clk          (clk),
        .rst          (rst),
        .state_q      (state_q),
        .state_d      (state_d),
        .run_ratio    (run_ratio),
        .run_vid      (run_vid),
        .xh_ratio_cfg (xh_ratio_cfg),
        .xh_vid_cfg   (xh_vid_cfg),
        .ratio_q      (ratio_o),
        .vid_q        (vid_o)
    );

    assign state_o  = state_q;
    assign snoop_en = in_snoop;
endmodule

// File: rtl/hps_checker.sv
module hps_checker
    import hps_pkg::*;
#(
    parameter int RATIO_W = 6,
    parameter int VID_W   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               halt_req,
    input logic               xhalt_en,
    input logic               snoop_req,
    input logic               intr,
    input logic               snoop_done,
    input logic [ST_W-1:0]    state_o,
    input logic [RATIO_W-1:0] ratio_o,
    input logic [VID_W-1:0]   vid_o,
    input logic               snoop_en
);
    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(state_o) == 1); // R2

    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_RUN && !halt_req) |=> state_o == ST_RUN); // R3

    AST_PLAIN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_RUN && halt_req && !xhalt_en) |=> state_o == ST_HALT); // R4

    AST_EXT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_RUN && halt_req && xhalt_en) |=> state_o == ST_XHALT); // R5

    AST_XSNP_POINT: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_XHALT_SNP) |=> (state_o != ST_XHALT_SNP) || ($stable(ratio_o) && $stable(vid_o))); // R7

    AST_SNOOP_END: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_XHALT_SNP && snoop_done) |=> state_o == ST_XHALT); // R8

    AST_SNOOP_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        (snoop_en) |=> state_o != ST_RUN); // R8

    AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (rst)
        ((state_o == ST_HALT || state_o == ST_XHALT) && snoop_req) |=> snoop_en); // R12
endmodule

bind halt_pwr_ctrl hps_checker #(
    .RATIO_W (RATIO_W),
    .VID_W   (VID_W)
) u_hps_checker (
    .clk        (clk),
    .rst        (rst),
    .halt_req   (halt_req),
    .xhalt_en   (xhalt_en),
    .snoop_req  (snoop_req),
    .intr       (intr),
    .snoop_done (snoop_done),
    .state_o    (state_o),
    .ratio_o    (ratio_o),
    .vid_o      (vid_o),
    .snoop_en   (snoop_en)
);

// File: tb/test_halt_pwr_ctrl.sv
module test_halt_pwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 6;
    localparam int VW = 8;

    localparam logic [4:0] S_RUN  = 5'b00001;
    localparam logic [4:0] S_HALT = 5'b00010;
    localparam logic [4:0] S_HSNP = 5'b00100;
    localparam logic [4:0] S_XH   = 5'b01000;
    localparam logic [4:0] S_XSNP = 5'b10000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          halt_req = 0, xhalt_en = 0, snoop_req = 0, intr = 0, snoop_done = 0;
    logic [RW-1:0] run_ratio = 6'd20, xh_ratio_cfg = 6'd6;
    logic [VW-1:0] run_vid = 8'h40, xh_vid_cfg = 8'h22;
    logic [4:0]    state_o;
    logic [RW-1:0] ratio_o;
    logic [VW-1:0] vid_o;
    logic          snoop_en;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    halt_pwr_ctrl #(.RATIO_W(RW), .VID_W(VW)) i_halt_pwr_ctrl (
        .clk(clk), .rst(rst), .halt_req(halt_req), .xhalt_en(xhalt_en),
        .snoop_req(snoop_req), .intr(intr), .snoop_done(snoop_done),
        .run_ratio(run_ratio), .run_vid(run_vid),
        .xh_ratio_cfg(xh_ratio_cfg), .xh_vid_cfg(xh_vid_cfg),
        .state_o(state_o), .ratio_o(ratio_o), .vid_o(vid_o), .snoop_en(snoop_en)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // drive a signal high for one edge, sampled at the following negedge
    task automatic pulse(input int which);
        case (which)
            0: halt_req = 1; 1: snoop_req = 1; 2: intr = 1; 3: snoop_done = 1;
            default: ;
        endcase
        tick();
        halt_req = 0; snoop_req = 0; intr = 0; snoop_done = 0;
    endtask

    task automatic t_reset();
        rst = 1; tick(); tick(); rst = 0;
        chk(state_o, S_RUN, "R1 state after reset");
        chk(snoop_en, 0, "R1 snoop_en after reset");
        chk(ratio_o, 20, "R1 ratio after reset");
        chk(vid_o, 8'h40, "R1 vid after reset");
        // later config changes must be ignored (R5)
        xh_ratio_cfg = 6'd9; xh_vid_cfg = 8'h11;
    endtask

    task automatic t_run_track();
        run_ratio = 6'd24; run_vid = 8'h48; tick();
        chk(ratio_o, 24, "R3 ratio tracks run input");
        chk(vid_o, 8'h48, "R3 vid tracks run input");
        pulse(1); pulse(2); pulse(3);
        chk(state_o, S_RUN, "R3 snoop/intr/done ignored in RUN");
    endtask

    task automatic t_plain_halt();
        xhalt_en = 0; pulse(0);
        chk(state_o, S_HALT, "R4 plain halt entered");
        chk(ratio_o, 24, "R4 ratio held in halt");
        pulse(0); pulse(3);
        chk(state_o, S_HALT, "R13 halt_req/snoop_done ignored in HALT");
        pulse(1);
        chk(state_o, S_HSNP, "R6 halt snoop entered");
        chk(snoop_en, 1, "R6 snoop_en in HALT_SNOOP");
        pulse(3);
        chk(state_o, S_HALT, "R8 back to HALT after snoop");
        chk(snoop_en, 0, "R6 snoop_en low in HALT");
        pulse(2);
        chk(state_o, S_RUN, "R9 wake from HALT");
        chk(ratio_o, 24, "R9 ratio after plain wake");
    endtask

    task automatic t_ext_halt();
        xhalt_en = 1; pulse(0);
        chk(state_o, S_XH, "R5 extended halt entered");
        chk(ratio_o, 6, "R5 reset-captured ratio");
        chk(vid_o, 8'h22, "R5 reset-captured vid");
        run_ratio = 6'd30; run_vid = 8'h50;
        pulse(1);
        chk(state_o, S_XSNP, "R6 extended snoop entered");
        chk(snoop_en, 1, "R6 snoop_en in XHALT_SNOOP");
        tick(); tick();
        chk(ratio_o, 6, "R7 ratio kept in XHALT_SNOOP");
        chk(vid_o, 8'h22, "R7 vid kept in XHALT_SNOOP");
        pulse(3);
        chk(state_o, S_XH, "R8 back to XHALT after snoop");
        pulse(2);
        chk(state_o, S_RUN, "R9 wake from XHALT");
        chk(ratio_o, 24, "R9 restored ratio");
        chk(vid_o, 8'h48, "R9 restored vid");
        tick();
        chk(ratio_o, 30, "R3 tracking resumes after wake");
    endtask

    task automatic t_int_in_snoop();
        pulse(0); pulse(1); pulse(2);
        chk(state_o, S_XSNP, "R10 intr during snoop does not wake");
        pulse(3);
        chk(state_o, S_XH, "R10 halt one cycle after done");
        tick();
        chk(state_o, S_RUN, "R10 latched intr wakes");
    endtask

    task automatic t_snoop_queue();
        pulse(0); pulse(1); pulse(1);
        chk(state_o, S_XSNP, "R11 second snoop held");
        pulse(3);
        chk(state_o, S_XH, "R11 halt between snoops");
        tick();
        chk(state_o, S_XSNP, "R11 queued snoop served");
        pulse(3);
        tick();
        chk(state_o, S_XH, "R11 no further snoop");
    endtask

    task automatic t_collide();
        snoop_req = 1; intr = 1; tick(); snoop_req = 0; intr = 0;
        chk(state_o, S_XSNP, "R12 snoop served before intr");
        pulse(3);
        chk(state_o, S_XH, "R12 halt after snoop");
        tick();
        chk(state_o, S_RUN, "R12 latched intr wakes");
        chk(ratio_o, 30, "R9 restored point");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_run_track();
        t_plain_halt();
        t_ext_halt();
        t_int_in_snoop();
        t_snoop_queue();
        t_collide();
        chk(state_o & (state_o - 5'd1), 0, "R2 state one-hot");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule